// File: doc/BRIEF.md
# Pad Configuration Register Bank

This block holds the static pad settings for a 97-pin I/O ring. Software reaches it through a simple word-oriented read/write bus. Each pin owns one 32-bit register. The fields of that register drive the pad ring directly, as four per-pin outputs:

- a pull-resistor enable
- a pull direction
- a two-bit drive-strength code
- on the lower pins only, a two-bit peripheral function select

The pin registers sit in three address windows, with unmapped gaps between them:

| Pins | Base offset | Stride |
|------|-------------|--------|
| 0 to 35 | 0x000 | 4 bytes |
| 36 to 52 | 0x100 | 4 bytes |
| 53 to 96 | 0x180 | 4 bytes |

The register offset of a pin is its window base plus four times its position inside that window. Any byte address that does not land on a pin register is refused: a read returns zero, a write has no effect, and the response carries an error flag.

The bus is always ready. Every request accepted on a clock edge gets exactly one response on the following cycle. For a read, that response carries the registered read data. For a write, the response data is zero.

Top module: `pad_cfg_bank`

## Requirements
- R1: After reset, every register field is zero: function select 0, drive code 0 (4 mA), bias-disable bit clear, pull direction 0. So `pull_en_o` is all ones, every other pad output is zero, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: The register of pin p is at byte offset 4*p for p in 0..35, 0x100+4*(p-36) for p in 36..52, and 0x180+4*(p-53) for p in 53..96. A write there followed by a read there returns the written field values.
- R3: Register bit 0 is the pull direction (1 = up, 0 = down) and drives `pull_up_o[p]`. Bit 1 disables the bias when set, and `pull_en_o[p]` is its inverse. Bits 6:5 are the drive code (0 = 4 mA, 1 = 6 mA, 2 = 8 mA, 3 = 9 mA) and drive `drive_o[2p+1:2p]`.
- R4: Bits 13:12 are the function-select code (0 = GPIO/default, 1 to 3 = alternates) and drive `fsel_o[2p+1:2p]`. They exist only for pins 0..35. On pins 36..96 they read as zero, ignore writes, and the matching `fsel_o` bits stay zero.
- R5: All register bits other than 0, 1, 6:5 and 13:12 read as zero and ignore writes.
- R6: A request to an offset in a gap (0x090–0x0FC, 0x144–0x17C) or above 0x22C returns read data zero, changes no register, and raises `rsp_err_o` in its response.
- R7: A request whose address bits 1:0 are not zero is treated as unmapped: data zero, no write, `rsp_err_o` raised.
- R8: Each request accepted on a clock edge produces `rsp_valid_o` high for exactly the next cycle. Without a request, `rsp_valid_o` is low.
- R9: A write to a mapped register changes the corresponding pad outputs in the cycle after the accepting edge.
- R10: On cycles without a request, all pad outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Always high; requests are never stalled |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data; zero for writes and errors |
| rsp_err_o | output | 1 | Address is not a pin register |
| fsel_o | output | 194 | Function-select code, 2 bits per pin |
| drive_o | output | 194 | Drive-strength code, 2 bits per pin |
| pull_en_o | output | 97 | Pull resistor enabled, per pin |
| pull_up_o | output | 97 | Pull direction (1 = up), per pin |

## Verification
The assertions check four properties on every cycle:

- the one-cycle request-to-response relation
- zero data on an error response
- the absence of unimplemented bits in any read data
- the stability of every pad output across idle cycles and refused accesses

Only the bench scenarios can show the rest:

- that each window maps to the right pin with the right field positions
- that the gaps and misaligned addresses leave every register untouched
- that the select field is missing above pin 35
- that a write reaches the pad outputs in the next cycle

The bench shows these by writing distinct patterns to all 97 pins and reading back through the bus.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
  localparam int DATA_W   = 32;
  localparam int UP_BIT   = 0;
  localparam int DIS_BIT  = 1;
  localparam int DRV_LSB  = 5;
  localparam int FSEL_LSB = 12;

  typedef struct packed {
    logic [1:0] fsel;
    logic [1:0] drv;
    logic       dis;
    logic       up;
  } pad_cfg_t;

  function automatic logic [DATA_W-1:0] pack_word(pad_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[UP_BIT]          = c.up;
    w[DIS_BIT]         = c.dis;
    w[DRV_LSB +: 2]    = c.drv;
    w[FSEL_LSB +: 2]   = c.fsel;
    return w;
  endfunction
endpackage

// File: rtl/pad_win_dec.sv
// Maps a byte address onto a pin index across three windows.
module pad_win_dec #(
  parameter int ADDR_W  = 12,
  parameter int PIN_W   = 7,
  parameter int W0_PINS = 36,
  parameter int W1_PINS = 17,
  parameter int W2_PINS = 44,
  parameter int W1_BASE = 'h100,
  parameter int W2_BASE = 'h180
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [PIN_W-1:0]  pin_o
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W0_END = WIDX_W'(W0_PINS);
  localparam logic [WIDX_W-1:0] W1_LO  = WIDX_W'(W1_BASE / 4);
  localparam logic [WIDX_W-1:0] W1_END = WIDX_W'(W1_BASE / 4 + W1_PINS);
  localparam logic [WIDX_W-1:0] W1_OFF = WIDX_W'(W0_PINS);
  localparam logic [WIDX_W-1:0] W2_LO  = WIDX_W'(W2_BASE / 4);
  localparam logic [WIDX_W-1:0] W2_END = WIDX_W'(W2_BASE / 4 + W2_PINS);
  localparam logic [WIDX_W-1:0] W2_OFF = WIDX_W'(W0_PINS + W1_PINS);

  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] pidx;
  assign widx = addr_i[ADDR_W-1:2];

  always_comb begin
    hit_o = 1'b0;
    pidx  = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (widx < W0_END) begin
        hit_o = 1'b1;
        pidx  = widx;
      end else if (widx >= W1_LO && widx < W1_END) begin
        hit_o = 1'b1;
        pidx  = widx - W1_LO + W1_OFF;
      end else if (widx >= W2_LO && widx < W2_END) begin
        hit_o = 1'b1;
        pidx  = widx - W2_LO + W2_OFF;
      end
    end
  end

  assign pin_o = PIN_W'(pidx);

  logic unused_pidx_hi;
  assign unused_pidx_hi = ^pidx;
endmodule

// File: rtl/pad_cfg_cell.sv
// One pin's settings; function select only when HAS_FSEL.
module pad_cfg_cell
  import pad_cfg_pkg::*;
#(
  parameter bit HAS_FSEL = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       up_i,
  input  logic       dis_i,
  input  logic [1:0] drv_i,
  input  logic [1:0] fsel_i,
  output pad_cfg_t   cfg_o
);
  logic       up_q, dis_q;
  logic [1:0] drv_q, fsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dis_q <= 1'b0;
      drv_q <= 2'd0;
    end else if (we_i) begin
      up_q  <= up_i;
      dis_q <= dis_i;
      drv_q <= drv_i;
    end
  end

  if (HAS_FSEL) begin : g_fsel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   fsel_q <= 2'd0;
      else if (we_i) fsel_q <= fsel_i;
    end
  end else begin : g_nofsel
    assign fsel_q = 2'd0;
    logic unused_fsel;
    assign unused_fsel = ^fsel_i;
  end

  always_comb begin
    cfg_o      = '0;
    cfg_o.up   = up_q;
    cfg_o.dis  = dis_q;
    cfg_o.drv  = drv_q;
    cfg_o.fsel = fsel_q;
  end
endmodule

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank
  import pad_cfg_pkg::*;
#(
  parameter int NUM_PINS = 97,
  parameter int W0_PINS  = 36,
  parameter int W1_PINS  = 17,
  parameter int W1_BASE  = 'h100,
  parameter int W2_BASE  = 'h180,
  parameter int MUX_PINS = 36,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_we_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [31:0]           req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [31:0]           rsp_rdata_o,
  output logic                  rsp_err_o,
  output logic [2*NUM_PINS-1:0] fsel_o,
  output logic [2*NUM_PINS-1:0] drive_o,
  output logic [NUM_PINS-1:0]   pull_en_o,
  output logic [NUM_PINS-1:0]   pull_up_o
);
  localparam int W2_PINS = NUM_PINS - W0_PINS - W1_PINS;
  localparam int PIN_W   = $clog2(NUM_PINS);

  logic             hit;
  logic [PIN_W-1:0] pin;
  pad_cfg_t         cfg [NUM_PINS];
  logic             wr_go;
  logic [31:0]      rd_word;

  assign req_ready_o = 1'b1;
  assign wr_go       = req_valid_i & req_we_i & hit;

  pad_win_dec #(
    .ADDR_W (ADDR_W),  .PIN_W  (PIN_W),
    .W0_PINS(W0_PINS), .W1_PINS(W1_PINS), .W2_PINS(W2_PINS),
    .W1_BASE(W1_BASE), .W2_BASE(W2_BASE)
  ) u_dec (
    .addr_i(req_addr_i),
    .hit_o (hit),
    .pin_o (pin)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pad_cfg_cell #(.HAS_FSEL(g < MUX_PINS)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_go && (pin == PIN_W'(g))),
      .up_i  (req_wdata_i[UP_BIT]),
      .dis_i (req_wdata_i[DIS_BIT]),
      .drv_i (req_wdata_i[DRV_LSB +: 2]),
      .fsel_i(req_wdata_i[FSEL_LSB +: 2]),
      .cfg_o (cfg[g])
    );
    assign pull_up_o[g]     = cfg[g].up;
    assign pull_en_o[g]     = ~cfg[g].dis;
    assign drive_o[2*g +: 2] = cfg[g].drv;
    assign fsel_o[2*g +: 2]  = cfg[g].fsel;
  end

  assign rd_word = hit ? pack_word(cfg[pin]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i & ~hit;
      rsp_rdata_o <= (req_valid_i && !req_we_i) ? rd_word : '0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{req_wdata_i[31:14], req_wdata_i[11:7], req_wdata_i[4:2]};
endmodule

// File: rtl/pad_cfg_bank_chk.sv
module pad_cfg_bank_chk #(
  parameter int NUM_PINS = 97
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  rsp_valid_o,
  input logic [31:0]           rsp_rdata_o,
  input logic                  rsp_err_o,
  input logic [2*NUM_PINS-1:0] fsel_o,
  input logic [2*NUM_PINS-1:0] drive_o,
  input logic [NUM_PINS-1:0]   pull_en_o,
  input logic [NUM_PINS-1:0]   pull_up_o
);
  localparam logic [31:0] UNIMPL = ~32'h0000_3063;

  assert_rsp_follows_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_rsp_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_err_data_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_rdata_o == 32'h0);

  assert_err_no_effect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> ($stable(fsel_o) && $stable(drive_o) && $stable(pull_en_o) && $stable(pull_up_o)));

  assert_unimpl_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_rdata_o & UNIMPL) == 32'h0);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(fsel_o) && $stable(drive_o) && $stable(pull_en_o) && $stable(pull_up_o)));
endmodule

bind pad_cfg_bank pad_cfg_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .rsp_err_o  (rsp_err_o),
  .fsel_o     (fsel_o),
  .drive_o    (drive_o),
  .pull_en_o  (pull_en_o),
  .pull_up_o  (pull_up_o)
);

// File: tb/pad_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module pad_cfg_bank_tb_top;
  localparam int NP = 97;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic [2*NP-1:0] fsel_o, drive_o;
  logic [NP-1:0] pull_en_o, pull_up_o;

  always #10 clk_i = ~clk_i;

  pad_cfg_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .fsel_o(fsel_o), .drive_o(drive_o), .pull_en_o(pull_en_o), .pull_up_o(pull_up_o)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model [NP];
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pin_off(int p);
    if (p < 36) return p * 4;
    if (p < 53) return 'h100 + (p - 36) * 4;
    return 'h180 + (p - 53) * 4;
  endfunction

  function automatic logic [31:0] pin_mask(int p);
    return (p < 36) ? 32'h0000_3063 : 32'h0000_0063;
  endfunction

  // monitor: pops one expected response per valid cycle
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (sb.size() == 0) begin
        check("R8 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " data"}, rsp_rdata_o, e.data);
        check({e.req, " err"}, {31'd0, rsp_err_o}, {31'd0, e.err});
      end
    end
  end

  task automatic xfer(bit we, int addr, logic [31:0] wd, logic [31:0] ed, bit ee, string r);
    exp_t e;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_we_i    = we;
    req_addr_i  = addr[11:0];
    req_wdata_i = wd;
    e.data = ed; e.err = ee; e.req = r;
    sb.push_back(e);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_we_i    = 1'b0;
  endtask

  task automatic check_pad(int p, string r);
    check({r, " pull_up"}, {31'd0, pull_up_o[p]}, {31'd0, model[p][0]});
    check({r, " pull_en"}, {31'd0, pull_en_o[p]}, {31'd0, ~model[p][1]});
    check({r, " drive"}, {30'd0, drive_o[2*p +: 2]}, {30'd0, model[p][6:5]});
    check({r, " fsel"}, {30'd0, fsel_o[2*p +: 2]}, {30'd0, model[p][13:12]});
  endtask

  task automatic check_all_pads(string r);
    for (int p = 0; p < NP; p++) check_pad(p, r);
  endtask

  task automatic read_all(string r);
    for (int p = 0; p < NP; p++) xfer(1'b0, pin_off(p), '0, model[p], 1'b0, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) model[p] = 32'h0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    check("R1 ready", {31'd0, req_ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all_pads("R1 reset");
    read_all("R1 reset read");

    // R2 R3 R4 R5 R9: distinct pattern per pin, pad updates next cycle
    for (int p = 0; p < NP; p++) begin
      logic [31:0] wd;
      wd = 32'hA5A5_5A5A ^ (p * 32'h9E37_79B9);
      if (p == 0)  wd = 32'hFFFF_FFFF;
      if (p == 40) wd = 32'hFFFF_FFFF;
      xfer(1'b1, pin_off(p), wd, 32'h0, 1'b0, "R2 write");
      model[p] = wd & pin_mask(p);
      check_pad(p, "R9 write to pad");
    end
    check("R4 pin40 fsel", {30'd0, fsel_o[81:80]}, 32'd0);
    check("R3 pin0 drive 9mA", {30'd0, drive_o[1:0]}, 32'd3);
    read_all("R2 R5 readback");
    check_all_pads("R3 pads");

    // R6 unmapped offsets: gaps and above the last register
    xfer(1'b1, 'h090, 32'hFFFF_FFFF, 32'h0, 1'b1, "R6 gap0 lo write");
    xfer(1'b1, 'h0FC, 32'hFFFF_FFFF, 32'h0, 1'b1, "R6 gap0 hi write");
    xfer(1'b1, 'h144, 32'hFFFF_FFFF, 32'h0, 1'b1, "R6 gap1 lo write");
    xfer(1'b1, 'h17C, 32'hFFFF_FFFF, 32'h0, 1'b1, "R6 gap1 hi write");
    xfer(1'b1, 'h230, 32'hFFFF_FFFF, 32'h0, 1'b1, "R6 past end write");
    xfer(1'b1, 'hFFC, 32'hFFFF_FFFF, 32'h0, 1'b1, "R6 top write");
    xfer(1'b0, 'h090, '0, 32'h0, 1'b1, "R6 gap0 read");
    xfer(1'b0, 'h144, '0, 32'h0, 1'b1, "R6 gap1 read");
    xfer(1'b0, 'h230, '0, 32'h0, 1'b1, "R6 past end read");
    xfer(1'b0, 'h22C, '0, model[96], 1'b0, "R2 last reg read");
    check_all_pads("R6 pads untouched");

    // R7 misaligned
    xfer(1'b1, 'h001, 32'h0000_0000, 32'h0, 1'b1, "R7 misaligned write");
    xfer(1'b1, 'h102, 32'h0000_0000, 32'h0, 1'b1, "R7 misaligned write w1");
    xfer(1'b0, 'h183, '0, 32'h0, 1'b1, "R7 misaligned read");
    read_all("R6 R7 regs untouched");

    // R3 bias: disable then pull-down enabled on pin 60, drive code 2
    xfer(1'b1, pin_off(60), 32'h0000_0002, 32'h0, 1'b0, "R3 bias off");
    model[60] = 32'h2;
    check_pad(60, "R3 bias off");
    xfer(1'b1, pin_off(60), 32'h0000_0040, 32'h0, 1'b0, "R3 pulldown 8mA");
    model[60] = 32'h40;
    check_pad(60, "R3 pulldown 8mA");

    // R10 idle hold
    repeat (5) @(negedge clk_i);
    check_all_pads("R10 idle");

    repeat (3) @(negedge clk_i);
    check("R8 all responses seen", sb.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule